// File: doc/BRIEF.md
# Reconfigurable Distributed-Arithmetic FIR Filter

This block is an FIR filter that uses no multipliers. Each tap's coefficient is folded into small tables of subset sums. A group of GRP taps shares one table of 2^GRP words, and the word at a given address is the sum of the coefficients whose address bit is set. Each accepted sample is broken into its bit positions, and the filter handles those positions across Q parallel sections over R = DW/Q clock slots. In slot r, section q handles bit r + q·R of every stored sample. The P tables of a section are read in parallel and their words are summed by a pipelined adder tree. A per-section accumulator then weights each sum by its slot and collects it. At the end, a pipelined shift-adder tree weights each section by its bit offset and combines the sections into one full-width result.

The coefficients can be changed at run time. A write on the coefficient port stores one tap value. A sequencer then rewrites every subset-sum word of every table, one address per clock and all tables at once. Sample input is held off until that rewrite ends, and the rewrite never starts while a sample is still being read out of the tables. In streaming use the filter takes one sample every R clocks and returns one result per sample, after a latency that is fixed for each configuration.

Top module: `dafir_filter`

## Requirements
- R1: For each accepted sample, the filter returns the exact sum over i of coef[i] times the sample accepted i samples earlier, where i = 0 is the current sample. Samples and coefficients are two's complement, and the output is the full-width signed result.
- R2: The sign bit of each sample carries negative weight, and coefficients may be negative. With DW = CW = 8 and NT = 8, the most negative values give exact results: every coefficient at -128 with every sample at -128 yields 131072.
- R3: While in_valid stays high and no coefficient update is pending, a new sample is accepted exactly every R clocks. Each accepted sample produces one output, and out_valid pulses are never closer than R clocks apart.
- R4: out_valid is a one-cycle pulse. It is seen high after edge A + R + ceil(log2 P) + ceil(log2 Q), where A is the edge that accepted the sample. Results come out in acceptance order.
- R5: When cw_en is high at an edge, cw_data is stored as coefficient cw_idx and the tables are rewritten over 2^GRP clocks. On an idle filter, in_ready is low after the write edge and is first seen high after edge W + 2^GRP + 1, where W is the write edge. Samples accepted after the rewrite use the new value.
- R6: After reset, out_valid and in_ready are low, and all coefficients and stored samples are zero. A table rewrite runs at once, and in_ready is first seen high after the (2^GRP + 1)-th edge following reset release. The first output after reset is 0.
- R7: A coefficient write made while a sample is being processed does not change that sample's result. The table rewrite waits until the sample's slots have finished.
- R8: A sample presented with in_valid while in_ready is low is ignored and never enters the sample history.
- R9: Each section's accumulator restarts from zero for every sample. Back-to-back samples with no idle cycle between them give results that do not depend on the previous sample's partial sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is offered on in_data |
| in_data | input | DW | Sample, two's complement |
| in_ready | output | 1 | The filter can take a sample this cycle |
| cw_en | input | 1 | Coefficient write strobe |
| cw_idx | input | max(1, ceil(log2 NT)) | Tap number to write; 0 weights the newest sample |
| cw_data | input | CW | Coefficient value, two's complement |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_data | output | CW+DW+ceil(log2 NT)+1 | Filter result, two's complement |

## Verification
An impulse fed after a load of mixed-sign coefficients should read back the coefficients one by one. This separates a fault in tap ordering or table contents from a fault in the accumulation. A back-to-back sweep of all 256 sample codes through the same coefficients exercises every address pattern in each section, including the negatively weighted sign bit. It also checks the one-sample-per-R spacing and the fixed latency. An all-most-negative stream checks the widest result, and a bit-alternating stream with power-of-two coefficients shows any leakage of partial sums between consecutive samples. Three further patterns each target one control case: a coefficient write issued right after a sample is accepted, a sample pulsed while the table rewrite is running, and the first sample after reset with zero coefficients.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  // Width of an index that counts 0..n-1, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of register levels in a pairwise adder tree over n inputs.
  function automatic int tree_depth(input int n);
    return (n > 1) ? $clog2(n) : 0;
  endfunction

endpackage

// File: rtl/dafir_table.sv
// Subset-sum RAM of one tap group: one write port, NR combinational read ports.
module dafir_table #(
  parameter int TW  = 10,
  parameter int GRP = 4,
  parameter int NR  = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [GRP-1:0]           waddr,
  input  logic [TW-1:0]            wdata,
  input  logic [NR-1:0][GRP-1:0]   raddr,
  output logic [NR-1:0][TW-1:0]    rdata
);
  localparam int DEPTH = 1 << GRP;

  logic [TW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar k = 0; k < NR; k++) begin : g_rd
    assign rdata[k] = mem[raddr[k]];
  end
endmodule

// File: rtl/dafir_tree.sv
// Pairwise adder tree, one register level per halving, valid carried alongside.
module dafir_tree
  import dafir_pkg::*;
#(
  parameter int W = 20,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vin,
  input  logic [N-1:0][W-1:0] din,
  output logic                vout,
  output logic [W-1:0]        dout
);
  localparam int LV = tree_depth(N);
  localparam int NP = 1 << LV;

  logic [W-1:0] pad [NP];

  for (genvar i = 0; i < NP; i++) begin : g_pad
    if (i < N) begin : g_in
      assign pad[i] = din[i];
    end else begin : g_zero
      assign pad[i] = '0;
    end
  end

  for (genvar g = 0; g < LV; g++) begin : lv
    localparam int CNT = NP >> (g + 1);
    logic [W-1:0] nd [CNT];
    logic         v;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        for (int i = 0; i < CNT; i++) nd[i] <= pad[2*i] + pad[2*i+1];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) v <= 1'b0;
        else        v <= vin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        for (int i = 0; i < CNT; i++) nd[i] <= lv[g-1].nd[2*i] + lv[g-1].nd[2*i+1];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) v <= 1'b0;
        else        v <= lv[g-1].v;
      end
    end
  end

  if (LV == 0) begin : g_pass
    assign dout = pad[0];
    assign vout = vin;
  end else begin : g_out
    assign dout = lv[LV-1].nd[0];
    assign vout = lv[LV-1].v;
  end
endmodule

// File: rtl/dafir_sacc.sv
// Per-section accumulator: weights each slot sum by its slot and adds it up
// over R slots. The sign-bit slot is subtracted in the top section.
module dafir_sacc
  import dafir_pkg::*;
#(
  parameter int W        = 20,
  parameter int R        = 4,
  parameter bit NEG_LAST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vin,
  input  logic [W-1:0] sum,
  output logic [W-1:0] acc,
  output logic         done
);
  localparam int CNW = idx_w(R);

  logic [CNW-1:0] cnt;
  logic           first, last, clr;
  logic [W-1:0]   term, shifted;

  assign first = (cnt == '0);
  assign last  = (int'(cnt) == R - 1);
  assign clr   = vin && first;  // restart pulse, once per sample

  always_comb begin
    term    = (NEG_LAST && last) ? (~sum + 1'b1) : sum;
    shifted = term << cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= vin && last;
      if (vin) begin
        acc <= (clr ? '0 : acc) + shifted;
        cnt <= last ? '0 : cnt + 1'b1;
      end
    end
  end

  // R9: slot sums of one sample arrive without gaps, so a restart cannot be skipped.
  a_r9_slots_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (vin && !first) |-> $past(vin));
endmodule

// File: rtl/dafir_filter.sv
module dafir_filter
  import dafir_pkg::*;
#(
  parameter int NT  = 8,
  parameter int GRP = 4,
  parameter int DW  = 8,
  parameter int Q   = 2,
  parameter int CW  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [DW-1:0]              in_data,
  output logic                       in_ready,
  input  logic                       cw_en,
  input  logic [idx_w(NT)-1:0]       cw_idx,
  input  logic [CW-1:0]              cw_data,
  output logic                       out_valid,
  output logic [CW+DW+$clog2(NT):0]  out_data
);
  localparam int P   = NT / GRP;
  localparam int R   = DW / Q;
  localparam int TW  = CW + $clog2(GRP) + 1;
  localparam int OW  = CW + DW + $clog2(NT) + 1;
  localparam int SLW = idx_w(R);
  localparam int GW  = idx_w(R + 1);

  // ---------------- coefficients and table rewrite sequencer ----------------
  logic [CW-1:0]  coef [NT];
  logic           pend, rbld;
  logic [GRP-1:0] raddr;
  logic           busy;

  function automatic logic [TW-1:0] grp_sum(input int p, input logic [GRP-1:0] a);
    logic [TW-1:0] s;
    s = '0;
    for (int j = 0; j < GRP; j++)
      if (a[j]) s = s + {{(TW-CW){coef[p*GRP+j][CW-1]}}, coef[p*GRP+j]};
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b1;
      rbld  <= 1'b0;
      raddr <= '0;
      for (int i = 0; i < NT; i++) coef[i] <= '0;
    end else begin
      if (rbld) begin
        raddr <= raddr + 1'b1;
        if (&raddr) rbld <= 1'b0;
      end else if (pend && !busy) begin
        rbld  <= 1'b1;
        raddr <= '0;
        pend  <= 1'b0;
      end
      if (cw_en) begin
        if (int'(cw_idx) < NT) coef[cw_idx] <= cw_data;
        pend <= 1'b1;
      end
    end
  end

  // ---------------- sample history and slot control ----------------
  logic [DW-1:0]  taps [NT];
  logic [SLW-1:0] slot;
  logic           slot_last, accept;

  assign slot_last = busy && (int'(slot) == R - 1);
  assign in_ready  = !pend && !rbld && (!busy || slot_last);
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) taps[i] <= '0;
    end else if (accept) begin
      taps[0] <= in_data;
      for (int i = 1; i < NT; i++) taps[i] <= taps[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      slot <= '0;
    end else if (slot_last) begin
      busy <= 1'b0;
    end else if (busy) begin
      slot <= slot + 1'b1;
    end
  end

  // ---------------- subset-sum tables, shared by all sections ----------------
  logic [P-1:0][Q-1:0][GRP-1:0] ra;
  logic [P-1:0][Q-1:0][TW-1:0]  rd;
  logic [P-1:0][TW-1:0]         wd;

  always_comb begin
    for (int p = 0; p < P; p++) begin
      wd[p] = grp_sum(p, raddr);
      for (int q = 0; q < Q; q++)
        for (int j = 0; j < GRP; j++)
          ra[p][q][j] = taps[p*GRP+j][q*R + int'(slot)];
    end
  end

  for (genvar p = 0; p < P; p++) begin : g_tab
    dafir_table #(.TW(TW), .GRP(GRP), .NR(Q)) u_tab (
      .clk   (clk),
      .we    (rbld),
      .waddr (raddr),
      .wdata (wd[p]),
      .raddr (ra[p]),
      .rdata (rd[p])
    );
  end

  // ---------------- sections: adder tree then shift accumulator ----------------
  logic [Q-1:0][P-1:0][OW-1:0] sin;
  logic [Q-1:0][OW-1:0]        ssum, acc, fin;
  logic [Q-1:0]                sval, sdone;

  always_comb begin
    for (int q = 0; q < Q; q++)
      for (int p = 0; p < P; p++)
        sin[q][p] = {{(OW-TW){rd[p][q][TW-1]}}, rd[p][q]};
  end

  for (genvar q = 0; q < Q; q++) begin : g_sec
    dafir_tree #(.W(OW), .N(P)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .vin   (busy),
      .din   (sin[q]),
      .vout  (sval[q]),
      .dout  (ssum[q])
    );
    dafir_sacc #(.W(OW), .R(R), .NEG_LAST(q == Q - 1)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .vin   (sval[q]),
      .sum   (ssum[q]),
      .acc   (acc[q]),
      .done  (sdone[q])
    );
    assign fin[q] = acc[q] << (q * R);
  end

  // ---------------- shift-adder tree over the sections ----------------
  dafir_tree #(.W(OW), .N(Q)) u_fin (
    .clk   (clk),
    .rst_n (rst_n),
    .vin   (sdone[0]),
    .din   (fin),
    .vout  (out_valid),
    .dout  (out_data)
  );

  // ---------------- assertions ----------------
  logic [GW-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)                gap <= GW'(R);
    else if (out_valid)        gap <= GW'(1);
    else if (int'(gap) < R)    gap <= gap + 1'b1;
  end

  // R3: results are at least R clocks apart.
  a_r3_out_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(gap) >= R));

  // R7: the table rewrite never overlaps slot reads of a sample.
  a_r7_rebuild_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rbld |-> !busy);

  // R9: all sections finish a sample in the same cycle.
  a_r9_sections_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (sdone == '0) || (sdone == '1));
endmodule

// File: tb/dafir_filter_test.sv
module dafir_filter_test;
  localparam int NT  = 8;
  localparam int GRP = 4;
  localparam int DW  = 8;
  localparam int Q   = 2;
  localparam int CW  = 8;
  localparam int R   = DW / Q;
  localparam int AD  = 1 << GRP;
  localparam int LAT = R + $clog2(NT / GRP) + $clog2(Q);
  localparam int OW  = CW + DW + $clog2(NT) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          in_ready;
  logic          cw_en;
  logic [2:0]    cw_idx;
  logic [CW-1:0] cw_data;
  logic          out_valid;
  logic [OW-1:0] out_data;

  dafir_filter #(.NT(NT), .GRP(GRP), .DW(DW), .Q(Q), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;

  int     cyc = 0;
  int     runs = 0;
  int     fails = 0;
  bit     ended = 1'b0;
  bit     stream_on = 1'b0;
  int     last_acc = -1;
  string  cur = "R1";
  int     coefm [NT];
  int     hist  [NT];
  longint exp_q [$];
  int     when_q[$];
  string  tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input longint act, input longint expv);
    runs++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
    end
  endtask

  // Scoreboard, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(cur, "unexpected output", 1, 0);
        end else begin
          longint e;
          int     w;
          string  t;
          longint a;
          e = exp_q.pop_front();
          w = when_q.pop_front();
          t = tag_q.pop_front();
          a = $signed(out_data);
          check(t, "output value", a, e);
          check("R4", "latency", cyc - w, LAT);
        end
      end
      if (in_valid && in_ready) begin
        longint y;
        for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = $signed(in_data);
        y = 0;
        for (int i = 0; i < NT; i++) y += longint'(coefm[i]) * longint'(hist[i]);
        exp_q.push_back(y);
        when_q.push_back(cyc + 1);
        tag_q.push_back(cur);
        if (stream_on && last_acc >= 0) check("R3", "accept spacing", cyc + 1 - last_acc, R);
        last_acc = cyc + 1;
      end
      if (cw_en) coefm[cw_idx] = $signed(cw_data);
    end
  end

  // All tasks are entered just after a rising edge.
  task automatic send(input logic [7:0] v);
    in_valid = 1'b1;
    in_data  = v;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wrcoef(input int idx, input int v);
    cw_en   = 1'b1;
    cw_idx  = idx[2:0];
    cw_data = v[7:0];
    @(posedge clk); #1;
    cw_en = 1'b0;
  endtask

  task automatic wait_ready();
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic drain();
    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(posedge clk);
    repeat (LAT + 2) @(posedge clk);
    #1;
  endtask

  task automatic load(input int c0, input int c1, input int c2, input int c3,
                      input int c4, input int c5, input int c6, input int c7);
    wrcoef(0, c0); wrcoef(1, c1); wrcoef(2, c2); wrcoef(3, c3);
    wrcoef(4, c4); wrcoef(5, c5); wrcoef(6, c6); wrcoef(7, c7);
    wait_ready();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("WD", "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < NT; i++) begin coefm[i] = 0; hist[i] = 0; end
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    cw_en = 1'b0; cw_idx = '0; cw_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R6: reset state and initial rewrite length
    @(negedge clk);
    check("R6", "out_valid after reset", out_valid, 0);
    check("R6", "in_ready after reset", in_ready, 0);
    n = 0;
    while (!in_ready && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    check("R6", "edges until ready", n, AD + 1);
    @(posedge clk); #1;
    cur = "R6";
    send(8'd77);
    drain();

    // R5: rewrite length after a single write on an idle filter
    load(3, -5, 7, 127, -128, 1, 0, -2);
    wrcoef(5, 9);
    n = 0;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk); n++;
    end
    check("R5", "edges until ready after write", n, AD + 1);
    @(posedge clk); #1;
    cur = "R5";
    send(8'd1);
    drain();

    // R1: impulse reads back the coefficients in tap order
    cur = "R1";
    send(8'd1);
    for (int i = 0; i < NT; i++) send(8'd0);
    drain();

    // R2 / R3: all sample codes back to back
    cur = "R2";
    stream_on = 1'b1; last_acc = -1;
    for (int v = 0; v < 256; v++) send(v[7:0]);
    stream_on = 1'b0;
    drain();

    // R2: most negative operands everywhere
    load(-128, -128, -128, -128, -128, -128, -128, -128);
    cur = "R2";
    for (int i = 0; i < NT + 2; i++) send(8'h80);
    drain();

    // R9: alternating bit patterns, no idle cycles
    load(1, 2, 4, 8, 16, 32, 64, -128);
    cur = "R9";
    stream_on = 1'b1; last_acc = -1;
    for (int k = 0; k < 4; k++) begin
      send(8'h55); send(8'hAA); send(8'h80); send(8'h7F); send(8'hFF); send(8'h01);
    end
    stream_on = 1'b0;
    drain();

    // R7: write right after an accept does not touch that sample's result
    cur = "R7";
    send(8'h93);
    wrcoef(0, -77);
    wait_ready();
    send(8'h21); send(8'hE0);
    drain();

    // R8: a sample offered while not ready never enters history
    wrcoef(1, 5);
    in_valid = 1'b1; in_data = 8'd99;
    @(negedge clk);
    check("R8", "in_ready low during rewrite", in_ready, 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    wait_ready();
    cur = "R8";
    for (int i = 0; i < NT; i++) send(8'(i * 17 + 3));
    drain();

    report();
    $finish;
  end
endmodule